// File: doc/BRIEF.md
# Serial CRC Division Shift Register

A bit-serial polynomial divider that forms a 5-bit frame check sequence (FCS). A chain of one-bit stages shifts once per accepted bit, and the incoming data enters most significant bit first. The top stage acts as the feedback tap. Whenever the top stage holds a 1, that bit is folded back through exclusive-or gates into every stage whose divisor term is present. The default divisor is X^5 + X^4 + X^2 + 1.

On the transmit side, the register is cleared, the message is shifted in, and five zero bits follow it. The register then holds the remainder, which is sent after the message, top bit first. On the receive side, the same logic takes in the message followed by the received FCS. The zero flag then shows whether the division ended with no remainder. A strobe qualifies each bit, and the register keeps its contents whenever the strobe is low.

Top module: `crc_serial_divider`

## Requirements
- R1: While `clr_i` is high at a rising clock edge, every stage is cleared, so `rem_o` reads 0 after that edge. Clear takes priority over `bit_vld_i`.
- R2: While `bit_vld_i` is low (and `clr_i` is low), `rem_o` keeps its value across the clock edge, whatever `bit_i` is.
- R3: With `bit_vld_i` high and `rem_o[4]` equal to 0, the next `rem_o` is `{rem_o[3:0], bit_i}`.
- R4: With `bit_vld_i` high and `rem_o[4]` equal to 1, the next `rem_o` is `{rem_o[3:0], bit_i} ^ 5'b10101`. Bits 4, 2 and 0 of this mask are the low-order terms of the divisor 110101.
- R5: After a clear, a message shifted in MSB first and followed by five 0 bits leaves `rem_o` equal to M·X^5 mod P. For example, the message 1010001101 gives `rem_o` = 5'b01110.
- R6: After a clear, shifting in a message followed by its FCS leaves `rem_zero_o` at 1. If one message bit is flipped, `rem_zero_o` is 0.
- R7: `rem_zero_o` is 1 exactly when all five bits of `rem_o` are 0. It is a combinational output that follows `rem_o` with no added latency.
- R8: `rem_o[4]` is the FCS bit that is sent first. Sending `rem_o[4]` down to `rem_o[0]` after the message forms a codeword that R6 accepts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| clr_i | input | 1 | Synchronous clear of all stages |
| bit_vld_i | input | 1 | Qualifies `bit_i`; one shift per high cycle |
| bit_i | input | 1 | Serial data bit, MSB of the frame first |
| rem_o | output | 5 | Register contents; bit 4 is the feedback stage |
| rem_zero_o | output | 1 | High when every stage holds 0 |

## Verification
The clocked properties assume that `clr_i` is held high for the first edges, so that no stage is sampled before it has a known value. They also assume that `bit_vld_i` and `bit_i` are driven to 0 or 1 on every cycle. The stimulus drives every input away from the active edge and starts with a clear. It never leaves an input undriven. Between frames it issues clears and inserts idle cycles with the strobe low and random data, so the hold rule is exercised while the data bit toggles.

// File: rtl/crcsd_pkg.sv
package crcsd_pkg;

   // Low-order terms of the divisor; the X^W term is implied.
   localparam int          CRCSD_WIDTH = 5;
   localparam logic [4:0]  CRCSD_POLY  = 5'b10101;

   // A generator without a constant term only shifts zeros into stage 0.
   function automatic bit poly_is_legal(input int width, input logic [31:0] poly);
      return (width >= 2) && (width <= 32) && poly[0];
   endfunction

endpackage

// File: rtl/crcsd_stage.sv
module crcsd_stage #(
   parameter bit HAS_TAP = 1'b0
) (
   input  logic clk_i,
   input  logic clr_i,
   input  logic en_i,
   input  logic d_i,
   input  logic fb_i,
   output logic q_o
);

   logic nxt;

   generate
      if (HAS_TAP) begin : g_tap
         assign nxt = d_i ^ fb_i;
      end else begin : g_plain
         assign nxt = d_i;
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (clr_i)
         q_o <= 1'b0;
      else if (en_i)
         q_o <= nxt;
   end

endmodule

// File: rtl/crcsd_core.sv
module crcsd_core #(
   parameter int               WIDTH = crcsd_pkg::CRCSD_WIDTH,
   parameter logic [WIDTH-1:0] POLY  = crcsd_pkg::CRCSD_POLY
) (
   input  logic             clk_i,
   input  logic             clr_i,
   input  logic             vld_i,
   input  logic             bit_i,
   output logic [WIDTH-1:0] rem_o
);

   localparam int TOP = WIDTH - 1;

   initial begin
      assert (crcsd_pkg::poly_is_legal(WIDTH, 32'(POLY)))
         else $error("crcsd_core: illegal WIDTH/POLY");
   end

   logic [WIDTH-1:0] q;
   logic             fb;

   assign fb = q[TOP];

   for (genvar i = 0; i < WIDTH; i++) begin : g_stage
      logic d;
      if (i == 0) begin : g_head
         assign d = bit_i;
      end else begin : g_body
         assign d = q[i-1];
      end
      crcsd_stage #(.HAS_TAP(POLY[i])) u_stage (
         .clk_i (clk_i),
         .clr_i (clr_i),
         .en_i  (vld_i),
         .d_i   (d),
         .fb_i  (fb),
         .q_o   (q[i])
      );
   end

   assign rem_o = q;

   assert_clear_empties_R1: assert property (@(posedge clk_i)
      clr_i |=> (rem_o == '0));

   assert_hold_when_idle_R2: assert property (@(posedge clk_i) disable iff (clr_i)
      !vld_i |=> $stable(rem_o));

   assert_plain_shift_R3: assert property (@(posedge clk_i) disable iff (clr_i)
      (vld_i && !rem_o[TOP]) |=> (rem_o == {$past(rem_o[TOP-1:0]), $past(bit_i)}));

   assert_feedback_shift_R4: assert property (@(posedge clk_i) disable iff (clr_i)
      (vld_i && rem_o[TOP]) |=> (rem_o == ({$past(rem_o[TOP-1:0]), $past(bit_i)} ^ POLY)));

endmodule

// File: rtl/crcsd_zero.sv
module crcsd_zero #(
   parameter int WIDTH = crcsd_pkg::CRCSD_WIDTH,
   parameter int GROUP = 4
) (
   input  logic             clk_i,
   input  logic             clr_i,
   input  logic [WIDTH-1:0] rem_i,
   output logic             zero_o
);

   localparam int NGRP = (WIDTH + GROUP - 1) / GROUP;

   initial begin
      assert (GROUP >= 1) else $error("crcsd_zero: GROUP must be positive");
   end

   logic [NGRP-1:0] any_set;

   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      localparam int LO = g * GROUP;
      localparam int HI = ((LO + GROUP) > WIDTH) ? WIDTH - 1 : LO + GROUP - 1;
      assign any_set[g] = |rem_i[HI:LO];
   end

   assign zero_o = ~|any_set;

   assert_zero_after_clear_R7: assert property (@(posedge clk_i)
      clr_i |=> zero_o);

endmodule

// File: rtl/crc_serial_divider.sv
module crc_serial_divider #(
   parameter int                WIDTH = crcsd_pkg::CRCSD_WIDTH,
   parameter logic [WIDTH-1:0]  POLY  = crcsd_pkg::CRCSD_POLY
) (
   input  logic             clk_i,
   input  logic             clr_i,
   input  logic             bit_vld_i,
   input  logic             bit_i,
   output logic [WIDTH-1:0] rem_o,
   output logic             rem_zero_o
);

   logic [WIDTH-1:0] rem;

   crcsd_core #(.WIDTH(WIDTH), .POLY(POLY)) u_core (
      .clk_i (clk_i),
      .clr_i (clr_i),
      .vld_i (bit_vld_i),
      .bit_i (bit_i),
      .rem_o (rem)
   );

   crcsd_zero #(.WIDTH(WIDTH)) u_zero (
      .clk_i  (clk_i),
      .clr_i  (clr_i),
      .rem_i  (rem),
      .zero_o (rem_zero_o)
   );

   assign rem_o = rem;

   // R8: the feedback stage leaves first, so it must be the output MSB
   assert_msb_is_tap_R8: assert property (@(posedge clk_i) disable iff (clr_i)
      (bit_vld_i && !rem_o[WIDTH-1]) |=> (rem_o[WIDTH-1] == $past(rem_o[WIDTH-2])));

endmodule

// File: tb/test_crc_serial_divider.sv
module test_crc_serial_divider;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       clr = 1'b1;
   logic       vld = 1'b0;
   logic       din = 1'b0;
   logic [4:0] rem;
   logic       zero;

   int  model_rem = 0;
   int  vectors = 0;
   int  miscompares = 0;
   bit  done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   crc_serial_divider i_crc_serial_divider (
      .clk_i      (clk),
      .clr_i      (clr),
      .bit_vld_i  (vld),
      .bit_i      (din),
      .rem_o      (rem),
      .rem_zero_o (zero)
   );

   task automatic compare(input string req);
      vectors++;
      if (rem !== model_rem[4:0]) begin
         miscompares++;
         $display("FAIL %s rem_o actual=%b expected=%b", req, rem, model_rem[4:0]);
      end
      if (zero !== (model_rem == 0)) begin
         miscompares++;
         $display("FAIL R7 rem_zero_o actual=%b expected=%b", zero, (model_rem == 0));
      end
   endtask

   // Called at a falling edge; returns at the next falling edge.
   task automatic step(input bit v, input bit b, input bit c);
      string req;
      req = c ? "R1" : (!v ? "R2" : (model_rem[4] ? "R4" : "R3"));
      vld = v; din = b; clr = c;
      @(posedge clk);
      if (c) model_rem = 0;
      else if (v) begin
         model_rem = (model_rem << 1) | int'(b);
         if (model_rem >= 32) model_rem = model_rem ^ 'h35;
      end
      @(negedge clk);
      compare(req);
   endtask

   task automatic check_val(input string req, input string what, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic send(input logic [31:0] bits, input int len);
      for (int i = len - 1; i >= 0; i--) step(1'b1, bits[i], 1'b0);
   endtask

   initial begin
      logic [31:0] msg;
      logic [4:0]  fcs;
      int          len;

      @(negedge clk);
      step(1'b0, 1'b1, 1'b1);
      check_val("R1", "rem_o after clear", int'(rem), 0);
      check_val("R7", "zero after clear", int'(zero), 1);

      // Known frame: 1010001101 -> remainder 01110
      send(32'b1010001101, 10);
      send(32'b0, 5);
      check_val("R5", "remainder of example", int'(rem), 5'b01110);
      fcs = rem;

      // R8: send FCS MSB first after the message
      step(1'b0, 1'b0, 1'b1);
      send(32'b1010001101, 10);
      for (int i = 4; i >= 0; i--) step(1'b1, fcs[i], 1'b0);
      check_val("R6", "zero on clean codeword", int'(zero), 1);

      // One flipped bit must be detected
      step(1'b0, 1'b0, 1'b1);
      send(32'b1010101101, 10);
      for (int i = 4; i >= 0; i--) step(1'b1, fcs[i], 1'b0);
      check_val("R6", "zero on corrupted codeword", int'(zero), 0);

      // Idle cycles with toggling data must hold the register
      for (int i = 0; i < 6; i++) step(1'b0, i[0], 1'b0);
      check_val("R2", "rem_o held while idle", int'(rem), int'(model_rem[4:0]));

      // Clear takes priority over a valid bit mid-frame
      send(32'b1101, 4);
      step(1'b1, 1'b1, 1'b1);
      check_val("R1", "clear over valid", int'(rem), 0);

      // Random frames: transmit, then receive with gaps
      for (int f = 0; f < 40; f++) begin
         len = $urandom_range(24, 1);
         msg = $urandom;
         step(1'b0, 1'b0, 1'b1);
         for (int i = len - 1; i >= 0; i--) begin
            step(1'b1, msg[i], 1'b0);
            if ($urandom_range(3, 0) == 0) step(1'b0, 1'($urandom), 1'b0);
         end
         send(32'b0, 5);
         fcs = rem;
         step(1'b0, 1'b0, 1'b1);
         for (int i = len - 1; i >= 0; i--) begin
            step(1'b1, msg[i], 1'b0);
            if ($urandom_range(3, 0) == 0) step(1'b0, 1'($urandom), 1'b0);
         end
         for (int i = 4; i >= 0; i--) step(1'b1, fcs[i], 1'b0);
         check_val("R6", "zero on random codeword", int'(zero), 1);
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

endmodule